// File: doc/BRIEF.md
# Set/Clear GPIO Port Controller

A bank of general-purpose I/O ports, each 32 pins wide, controlled through a simple 32-bit register port. Software never rewrites a whole control register. Each control register has one read view and two write aliases. Ones written to the set alias turn bits on. Ones written to the clear alias turn bits off. Zero bits leave their pins alone. This lets independent software agents reconfigure disjoint pins without a read-modify-write race.

A pin's role comes from four bits read together: function, select, trigger and direction.
- Function high hands the pin to one of two alternate peripherals, and select picks which one.
- Function low with select low makes the pin plain GPIO, where direction chooses output or input.
- Function low with select high makes the pin an interrupt input. Trigger chooses level or edge, and direction chooses the polarity.

Pad inputs are synchronised before use. Interrupt hits latch sticky per-pin flags, and unmasked flags of interrupt-mode pins are merged into one interrupt line.

Top module: `gpio_ctrl`

## Requirements
- R1: A write to the data set alias (low byte 0x14) ORs the word into the output data register, and a write to the clear alias (0x18) clears the bits that are one. The register reads back at 0x10.
- R2: The same set/clear behaviour applies to the other control registers.
  - Mask: view 0x20, set 0x24, clear 0x28.
  - Function: view 0x40, set 0x44, clear 0x48.
  - Select: view 0x50, set 0x54, clear 0x58.
  - Direction: view 0x60, set 0x64, clear 0x68.
  - Trigger: view 0x70, set 0x74, clear 0x78.
- R3: After reset, every pin is a GPIO input. Data, function, select, direction, trigger and flags are all zero. Every mask bit is one. Pull-disable bits are zero where a pull exists, and the interrupt output is low.
- R4: Offset 0x00 returns the pad inputs through a two-flop synchroniser. A pad change is visible after the second rising clock edge and not after the first.
- R5: With function=0, select=0 and direction=1, a pin drives its data bit with output enable high. With direction=0 the output enable is low.
- R6: With function=1, select=0 routes the first alternate function's output and enable to the pad, and select=1 routes the second.
- R7: A pin with function=0 and select=1 is an interrupt input, and its output enable is low.
- R8: A level interrupt pin (trigger=0) sets its flag on every cycle that the active level is present. Direction=1 means high is active and direction=0 means low is active. A flag clear written while the level persists leaves the flag set.
- R9: An edge interrupt pin (trigger=1) sets its flag on a rising edge (direction=1) or a falling edge (direction=0), and not on the opposite edge. The flag stays set until a one is written to that bit at the flag-clear offset 0x84. The flags read at 0x80.
- R10: `irq_o` is high exactly when some interrupt-mode pin has its flag set and its mask clear. A masked pin still latches its flag.
- R11: `pad_pull_en_o` is the inverse of the pull-disable register (view 0x30, set 0x34, clear 0x38). Pins without pull capability read a disable bit of one, ignore clear writes, and never enable a pull. By default the third port has no pull on bit 31, and the fourth port has none on bits 29 and 24.
- R12: Address bits [9:8] select one of four ports spaced 0x100 apart. An access to one port leaves the other ports unchanged.
- R13: Reads return zero for a set or clear alias, for an unmapped offset and for a misaligned address. Writes to the read-only views 0x00 and 0x80 have no effect.
- R14: A pin that is not in interrupt mode never raises its flag, whatever its input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Register access strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W (10) | Byte address: port in [9:8], register in [7:0] |
| req_wdata_i | input | PINS (32) | Write data |
| rsp_rdata_o | output | PINS (32) | Read data, combinational from the address during a read |
| pad_in_i | input | NUM_PORTS*PINS | Pad input levels |
| pad_out_o | output | NUM_PORTS*PINS | Pad output values |
| pad_oe_o | output | NUM_PORTS*PINS | Pad output enables |
| pad_pull_en_o | output | NUM_PORTS*PINS | Pad pull-up enables |
| alt0_out_i | input | NUM_PORTS*PINS | First alternate function output |
| alt0_oe_i | input | NUM_PORTS*PINS | First alternate function enable |
| alt1_out_i | input | NUM_PORTS*PINS | Second alternate function output |
| alt1_oe_i | input | NUM_PORTS*PINS | Second alternate function enable |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is a flag-clear write that lands while a level interrupt is still active. It needs a pin configured for level mode and a pad held at its active level for more than the synchroniser delay, with the clear write issued in that window. The stimulus orders its configuration writes so that trigger and direction are set before select, which avoids spurious flags. It then holds the pad level, clears, and reads the flag back before releasing the pad. Edge pins get both polarities of pulse, so that the opposite edge is seen not to flag. A masked pin is driven active to show that the flag latches without raising the interrupt line.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // register index = addr[7:4]
  localparam logic [3:0] REG_LEVEL = 4'd0;
  localparam logic [3:0] REG_DATA  = 4'd1;
  localparam logic [3:0] REG_MASK  = 4'd2;
  localparam logic [3:0] REG_PULL  = 4'd3;
  localparam logic [3:0] REG_FUNC  = 4'd4;
  localparam logic [3:0] REG_SEL   = 4'd5;
  localparam logic [3:0] REG_DIR   = 4'd6;
  localparam logic [3:0] REG_TRIG  = 4'd7;
  localparam logic [3:0] REG_FLAG  = 4'd8;
  localparam int CFG_FIRST = 1;
  localparam int CFG_LAST  = 7;

  // access kind = addr[3:2]
  typedef enum logic [1:0] {
    OP_VIEW = 2'd0,
    OP_W1S  = 2'd1,  // on the flag register this slot is the clear alias
    OP_W1C  = 2'd2,
    OP_NONE = 2'd3
  } op_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
  parameter int         W     = 32,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter logic [W-1:0] FIXED   = '0   // bits that ignore clear writes
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (set_i) q_d = q_q | wdata_i;
    if (clr_i) q_d = q_q & ~(wdata_i & ~FIXED);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= RST_VAL;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] irq_mode_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] trig_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] prev_q, flag_q;
  logic [W-1:0] rise, fall, hit;

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;
  assign hit  = (~trig_i &  dir_i &  lvl_i)
              | (~trig_i & ~dir_i & ~lvl_i)
              | ( trig_i &  dir_i &  rise)
              | ( trig_i & ~dir_i &  fall);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= lvl_i;
      flag_q <= (flag_q & ~clr_i) | (hit & irq_mode_i);  // set wins
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/gpio_port.sv
module gpio_port import gpio_pkg::*; #(
  parameter int           PINS     = 32,
  parameter logic [PINS-1:0] PULL_CAP = '1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [3:0]      reg_i,
  input  logic [1:0]      op_i,
  input  logic [PINS-1:0] wdata_i,
  input  logic [PINS-1:0] pad_in_i,
  input  logic [PINS-1:0] alt0_out_i,
  input  logic [PINS-1:0] alt0_oe_i,
  input  logic [PINS-1:0] alt1_out_i,
  input  logic [PINS-1:0] alt1_oe_i,
  output logic [PINS-1:0] pad_out_o,
  output logic [PINS-1:0] pad_oe_o,
  output logic [PINS-1:0] pull_en_o,
  output logic [PINS-1:0] rdata_o,
  output logic [PINS-1:0] flag_o,
  output logic [PINS-1:0] mask_o,
  output logic [PINS-1:0] irq_mode_o
);
  logic [PINS-1:0] cfg_q [CFG_FIRST:CFG_LAST];
  logic [PINS-1:0] lvl, flag, fun, sel, dir, trg, data, gpio_mode, irq_mode, alt0_sel, alt1_sel;
  logic            flag_clr;

  for (genvar i = CFG_FIRST; i <= CFG_LAST; i++) begin : g_cfg
    localparam logic [3:0] IDX = 4'(i);
    localparam logic [PINS-1:0] RST =
      (IDX == REG_MASK) ? '1 : (IDX == REG_PULL) ? ~PULL_CAP : '0;
    localparam logic [PINS-1:0] FIX =
      (IDX == REG_PULL) ? ~PULL_CAP : '0;

    gpio_setclr_reg #(.W(PINS), .RST_VAL(RST), .FIXED(FIX)) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (wr_en_i && reg_i == IDX && op_i == OP_W1S),
      .clr_i   (wr_en_i && reg_i == IDX && op_i == OP_W1C),
      .wdata_i (wdata_i),
      .q_o     (cfg_q[i])
    );
  end

  gpio_sync #(.W(PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (lvl)
  );

  assign data = cfg_q[REG_DATA];
  assign fun  = cfg_q[REG_FUNC];
  assign sel  = cfg_q[REG_SEL];
  assign dir  = cfg_q[REG_DIR];
  assign trg  = cfg_q[REG_TRIG];

  assign gpio_mode = ~fun & ~sel;
  assign irq_mode  = ~fun &  sel;
  assign alt0_sel  =  fun & ~sel;
  assign alt1_sel  =  fun &  sel;

  assign flag_clr = wr_en_i && reg_i == REG_FLAG && op_i == OP_W1S;

  gpio_irq_detect #(.W(PINS)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lvl_i      (lvl),
    .irq_mode_i (irq_mode),
    .dir_i      (dir),
    .trig_i     (trg),
    .clr_i      (flag_clr ? wdata_i : '0),
    .flag_o     (flag)
  );

  assign pad_oe_o  = (alt0_sel & alt0_oe_i) | (alt1_sel & alt1_oe_i) | (gpio_mode & dir);
  assign pad_out_o = (alt0_sel & alt0_out_i) | (alt1_sel & alt1_out_i) | (gpio_mode & dir & data);
  assign pull_en_o = ~cfg_q[REG_PULL];

  always_comb begin
    rdata_o = '0;
    if (op_i == OP_VIEW) begin
      if (reg_i == REG_LEVEL)                           rdata_o = lvl;
      else if (reg_i == REG_FLAG)                       rdata_o = flag;
      else if (reg_i >= 4'(CFG_FIRST) && reg_i <= 4'(CFG_LAST)) begin
        for (int i = CFG_FIRST; i <= CFG_LAST; i++)
          if (reg_i == 4'(i)) rdata_o = cfg_q[i];
      end
    end
  end

  assign flag_o     = flag;
  assign mask_o     = cfg_q[REG_MASK];
  assign irq_mode_o = irq_mode;
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl import gpio_pkg::*; #(
  parameter int NUM_PORTS = 4,
  parameter int PINS      = 32,
  parameter logic [NUM_PORTS*PINS-1:0] PULL_CAP =
    {32'hdeff_ffff, 32'h7fff_ffff, 32'hffff_ffff, 32'hffff_ffff},
  parameter int ADDR_W    = $clog2(NUM_PORTS) + 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  input  logic                      req_write_i,
  input  logic [ADDR_W-1:0]         req_addr_i,
  input  logic [PINS-1:0]           req_wdata_i,
  output logic [PINS-1:0]           rsp_rdata_o,
  input  logic [NUM_PORTS*PINS-1:0] pad_in_i,
  output logic [NUM_PORTS*PINS-1:0] pad_out_o,
  output logic [NUM_PORTS*PINS-1:0] pad_oe_o,
  output logic [NUM_PORTS*PINS-1:0] pad_pull_en_o,
  input  logic [NUM_PORTS*PINS-1:0] alt0_out_i,
  input  logic [NUM_PORTS*PINS-1:0] alt0_oe_i,
  input  logic [NUM_PORTS*PINS-1:0] alt1_out_i,
  input  logic [NUM_PORTS*PINS-1:0] alt1_oe_i,
  output logic                      irq_o
);
  localparam int PSEL_W = ADDR_W - 8;

  logic                      aligned;
  logic [3:0]                reg_idx;
  logic [1:0]                op;
  logic [PSEL_W-1:0]         port_idx;
  logic [PINS-1:0]           rd_arr [NUM_PORTS];
  logic [NUM_PORTS*PINS-1:0] flag_all, mask_all, irqm_all;

  assign aligned  = req_addr_i[1:0] == 2'b00;
  assign op       = req_addr_i[3:2];
  assign reg_idx  = req_addr_i[7:4];
  assign port_idx = req_addr_i[ADDR_W-1:8];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic wr_en;
    assign wr_en = req_valid_i && req_write_i && aligned && port_idx == PSEL_W'(p);

    gpio_port #(.PINS(PINS), .PULL_CAP(PULL_CAP[p*PINS +: PINS])) u_port (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr_en),
      .reg_i      (reg_idx),
      .op_i       (op),
      .wdata_i    (req_wdata_i),
      .pad_in_i   (pad_in_i[p*PINS +: PINS]),
      .alt0_out_i (alt0_out_i[p*PINS +: PINS]),
      .alt0_oe_i  (alt0_oe_i[p*PINS +: PINS]),
      .alt1_out_i (alt1_out_i[p*PINS +: PINS]),
      .alt1_oe_i  (alt1_oe_i[p*PINS +: PINS]),
      .pad_out_o  (pad_out_o[p*PINS +: PINS]),
      .pad_oe_o   (pad_oe_o[p*PINS +: PINS]),
      .pull_en_o  (pad_pull_en_o[p*PINS +: PINS]),
      .rdata_o    (rd_arr[p]),
      .flag_o     (flag_all[p*PINS +: PINS]),
      .mask_o     (mask_all[p*PINS +: PINS]),
      .irq_mode_o (irqm_all[p*PINS +: PINS])
    );
  end

  always_comb begin
    rsp_rdata_o = '0;
    if (req_valid_i && !req_write_i && aligned) begin
      for (int p = 0; p < NUM_PORTS; p++)
        if (port_idx == PSEL_W'(p)) rsp_rdata_o = rd_arr[p];
    end
  end

  assign irq_o = |(flag_all & ~mask_all & irqm_all);
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk #(
  parameter int NUM_PORTS = 4,
  parameter int PINS      = 32,
  parameter logic [NUM_PORTS*PINS-1:0] PULL_CAP = '1
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      irq_o,
  input logic [NUM_PORTS*PINS-1:0] pad_oe_o,
  input logic [NUM_PORTS*PINS-1:0] pad_pull_en_o,
  input logic [NUM_PORTS*PINS-1:0] flag_all,
  input logic [NUM_PORTS*PINS-1:0] mask_all,
  input logic [NUM_PORTS*PINS-1:0] irqm_all
);
  a_r11_no_pull_without_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_pull_en_o & ~PULL_CAP) == '0);

  a_r10_irq_needs_open_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_all & ~mask_all) != '0);

  a_r7_irq_pin_undriven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irqm_all & pad_oe_o) == '0);

  a_r14_new_flag_in_irq_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_all & ~$past(flag_all) & ~$past(irqm_all)) == '0);

  a_r3_irq_known: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(irq_o));
endmodule

bind gpio_ctrl gpio_ctrl_chk #(
  .NUM_PORTS (NUM_PORTS),
  .PINS      (PINS),
  .PULL_CAP  (PULL_CAP)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .irq_o         (irq_o),
  .pad_oe_o      (pad_oe_o),
  .pad_pull_en_o (pad_pull_en_o),
  .flag_all      (flag_all),
  .mask_all      (mask_all),
  .irqm_all      (irqm_all)
);

// File: tb/sim_gpio_ctrl.sv
module sim_gpio_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int W  = 32;

  logic            clk = 0;
  logic            rst_n = 0;
  logic            valid = 0, write = 0;
  logic [9:0]      addr = '0;
  logic [W-1:0]    wdata = '0;
  logic [W-1:0]    rdata;
  logic [NP*W-1:0] pad_in = '0, pad_out, pad_oe, pull_en;
  logic [NP*W-1:0] a0_out = '0, a0_oe = '0, a1_out = '0, a1_oe = '0;
  logic            irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_write_i(write),
    .req_addr_i(addr), .req_wdata_i(wdata), .rsp_rdata_o(rdata),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe), .pad_pull_en_o(pull_en),
    .alt0_out_i(a0_out), .alt0_oe_i(a0_oe), .alt1_out_i(a1_out), .alt1_oe_i(a1_oe),
    .irq_o(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [9:0]  addr;
    logic [31:0] data;   // write data, or expected read data
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 10'h014, 32'h0000_00f0, 4'd1},   // R1 set
    '{1'b0, 10'h010, 32'h0000_00f0, 4'd1},
    '{1'b1, 10'h018, 32'h0000_0030, 4'd1},   // R1 clear
    '{1'b0, 10'h010, 32'h0000_00c0, 4'd1},
    '{1'b1, 10'h028, 32'h0000_ffff, 4'd2},   // R2 mask clear
    '{1'b0, 10'h020, 32'hffff_0000, 4'd2},
    '{1'b1, 10'h044, 32'h0000_000a, 4'd2},   // R2 function
    '{1'b0, 10'h040, 32'h0000_000a, 4'd2},
    '{1'b1, 10'h048, 32'h0000_0002, 4'd2},
    '{1'b0, 10'h040, 32'h0000_0008, 4'd2},
    '{1'b1, 10'h048, 32'h0000_0008, 4'd2},
    '{1'b0, 10'h040, 32'h0000_0000, 4'd2},
    '{1'b1, 10'h074, 32'h0000_0003, 4'd2},   // R2 trigger
    '{1'b0, 10'h070, 32'h0000_0003, 4'd2},
    '{1'b1, 10'h078, 32'h0000_0001, 4'd2},
    '{1'b0, 10'h070, 32'h0000_0002, 4'd2},
    '{1'b1, 10'h078, 32'h0000_0002, 4'd2},
    '{1'b0, 10'h014, 32'h0000_0000, 4'd13},  // R13 alias reads zero
    '{1'b0, 10'h0a0, 32'h0000_0000, 4'd13},
    '{1'b0, 10'h088, 32'h0000_0000, 4'd13},
    '{1'b1, 10'h000, 32'h0000_ffff, 4'd13},  // R13 read-only views
    '{1'b0, 10'h000, 32'h0000_0000, 4'd13},
    '{1'b1, 10'h080, 32'hffff_ffff, 4'd13},
    '{1'b0, 10'h080, 32'h0000_0000, 4'd13},
    '{1'b1, 10'h114, 32'h0000_0005, 4'd12},  // R12 port isolation
    '{1'b0, 10'h110, 32'h0000_0005, 4'd12},
    '{1'b0, 10'h010, 32'h0000_00c0, 4'd12},
    '{1'b0, 10'h230, 32'h8000_0000, 4'd11},  // R11 pull capability
    '{1'b1, 10'h238, 32'hffff_ffff, 4'd11},
    '{1'b0, 10'h230, 32'h8000_0000, 4'd11},
    '{1'b0, 10'h330, 32'h2100_0000, 4'd11},
    '{1'b1, 10'h334, 32'h0000_000f, 4'd11},
    '{1'b0, 10'h330, 32'h2100_000f, 4'd11},
    '{1'b0, 10'h011, 32'h0000_0000, 4'd13}   // R13 misaligned
  };

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [W-1:0] d);
    @(negedge clk);
    valid = 1; write = 1; addr = a; wdata = d;
    @(negedge clk);
    valid = 0; write = 0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [W-1:0] d);
    @(negedge clk);
    valid = 1; write = 0; addr = a;
    #1 d = rdata;
    valid = 0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [W-1:0] r;
    wait_n(3);
    rst_n = 1;
    wait_n(1);

    // R3 reset state
    rd(10'h020, r); chk("R3 mask", r, 32'hffff_ffff);
    rd(10'h010, r); chk("R3 data", r, '0);
    rd(10'h080, r); chk("R3 flag", r, '0);
    rd(10'h060, r); chk("R3 dir", r, '0);
    rd(10'h330, r); chk("R3 pull", r, 32'h2100_0000);
    chk("R3 oe", pad_oe[31:0], '0);
    chk("R3 irq", {31'd0, irq}, '0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) wr(VEC[i].addr, VEC[i].data);
      else begin
        rd(VEC[i].addr, r);
        chk($sformatf("R%0d table %0d", VEC[i].req, i), r, VEC[i].data);
      end
    end

    // R11 pad pull enables
    chk("R11 port2 pulls", pull_en[64 +: 32], 32'h7fff_ffff);
    chk("R11 port3 pulls", pull_en[96 +: 32], 32'hdeff_fff0);

    // R4 two-flop input latency
    @(negedge clk); pad_in[3] = 1;
    rd(10'h000, r); chk("R4 after one edge", r, '0);
    rd(10'h000, r); chk("R4 after two edges", r, 32'h8);
    pad_in[3] = 0;

    // R5 GPIO output: data=0xC0, dir on pins 6,5
    wr(10'h064, 32'h60);
    chk("R5 oe", {29'd0, pad_oe[6:4]}, 32'h6);
    chk("R5 out", {29'd0, pad_out[6:4]}, 32'h4);

    // R6 alternate functions on port1 pin0
    a0_out[32] = 1; a0_oe[32] = 1; a1_out[32] = 0; a1_oe[32] = 0;
    wr(10'h144, 32'h1);
    chk("R6 alt0", {30'd0, pad_oe[32], pad_out[32]}, 32'h3);
    wr(10'h154, 32'h1);
    chk("R6 alt1", {30'd0, pad_oe[32], pad_out[32]}, 32'h0);

    // R14 GPIO input toggling never flags
    pad_in[4] = 1; wait_n(4); pad_in[4] = 0; wait_n(4);
    rd(10'h080, r); chk("R14 gpio no flag", r, '0);

    // pins 8..11: level-high, level-low, rise, fall; mode bits before select
    wr(10'h074, 32'h0c00);
    wr(10'h064, 32'h0500);
    wr(10'h054, 32'h0f00);
    chk("R7 irq pins undriven", {28'd0, pad_oe[11:8]}, '0);
    wait_n(2);
    rd(10'h080, r); chk("R8 low level flags", r, 32'h0200);
    chk("R10 irq unmasked", {31'd0, irq}, 32'h1);
    pad_in[9] = 1; wait_n(4);
    wr(10'h084, 32'h0200);
    rd(10'h080, r); chk("R9 flag clear", r, '0);
    chk("R10 irq low", {31'd0, irq}, '0);

    pad_in[8] = 1; wait_n(4);
    rd(10'h080, r); chk("R8 high level flags", r, 32'h0100);
    wr(10'h084, 32'h0100);
    rd(10'h080, r); chk("R8 clear while active", r, 32'h0100);
    pad_in[8] = 0; wait_n(4);
    wr(10'h084, 32'h0100);
    rd(10'h080, r); chk("R8 clear after release", r, '0);

    pad_in[10] = 1; wait_n(4); pad_in[10] = 0; wait_n(4);
    rd(10'h080, r); chk("R9 rising sticky", r, 32'h0400);
    wr(10'h084, 32'h0400);
    pad_in[11] = 1; wait_n(4);
    rd(10'h080, r); chk("R9 rise ignored on falling pin", r, '0);
    pad_in[11] = 0; wait_n(4);
    rd(10'h080, r); chk("R9 falling", r, 32'h0800);
    wr(10'h084, 32'h0800);

    // R10 masked pin 20 latches without irq
    wr(10'h064, 32'h0010_0000);
    wr(10'h054, 32'h0010_0000);
    pad_in[20] = 1; wait_n(4);
    rd(10'h080, r); chk("R10 masked flag", r, 32'h0010_0000);
    chk("R10 masked irq", {31'd0, irq}, '0);
    wr(10'h028, 32'h0010_0000);
    chk("R10 unmask irq", {31'd0, irq}, 32'h1);
    wr(10'h024, 32'h0010_0000);
    chk("R10 remask irq", {31'd0, irq}, '0);

    summary();
  end
endmodule